// File: doc/BRIEF.md
# Dual-Converter Start and Result Coordinator

This block sits between a trigger source and two analog-to-digital conversion engines, one leading and one following. A 4-bit coordination code selects how the two engines are started. With the independent code, each engine is started by its own trigger. With the three coupled codes, only the leading engine's trigger is used. In these codes the coordinator either starts both engines together or starts the following engine a fixed number of clock cycles after the leading one. There is a short and a long spacing, and both are set by parameters.

The coordinator also gathers the two conversion results into one 32-bit word, which is read through the leading engine's data location. A result-valid pulse marks each complete pair. The engines are modelled as plain start/done/data handshakes. The transfer-enable bit must be set for the paired result to be signalled, even when nothing is moved.

Top module: `dual_adc_sync`

## Requirements
- R1: The `mode` input is decoded as follows: 4'b0110 is joint start, 4'b0111 is short-spaced start, 4'b1000 is long-spaced start, and every other code, including 4'b0000, is independent operation.
- R2: In independent operation, `mst_start` pulses one cycle after `mst_ext_trig` is sampled high with `mst_trig_en` high. `slv_start` pulses one cycle after `slv_ext_trig` is sampled high with `slv_trig_en` high.
- R3: In the coupled codes, a start is issued only when `mst_ext_trig`, `mst_trig_en` and `slv_trig_en` are all high, and `slv_ext_trig` has no effect on `slv_start`.
- R4: In joint start, `mst_start` and `slv_start` pulse in the same cycle, one cycle after the accepted trigger.
- R5: In short-spaced start, `slv_start` pulses FAST_DLY (default 7) cycles after `mst_start`.
- R6: In long-spaced start, `slv_start` pulses SLOW_DLY (default 14) cycles after `mst_start`.
- R7: While a spaced slave start is still pending, further triggers are ignored, and no extra `mst_start` is issued.
- R8: `comb_data[15:0]` takes `mst_data` on `mst_done` in every code. `comb_data[31:16]` takes `slv_data` on `slv_done` in the coupled codes. Both updates become visible the cycle after the done pulse.
- R9: In joint start, `comb_valid` pulses one cycle after the later of the two done pulses, or after both if they arrive in the same cycle, and never twice for one pair.
- R10: In the spaced codes, `comb_valid` pulses one cycle after `slv_done`. In independent operation it never pulses.
- R11: `comb_valid` stays low whenever `dma_en` was low in the cycle that completed the pair.
- R12: While reset is asserted and right after it, `mst_start`, `slv_start`, `comb_valid` and `comb_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 4 | Coordination code |
| mst_trig_en | input | 1 | External trigger enable, leading engine |
| slv_trig_en | input | 1 | External trigger enable, following engine |
| dma_en | input | 1 | Transfer enable; gates the paired result pulse |
| mst_ext_trig | input | 1 | External trigger, leading engine |
| slv_ext_trig | input | 1 | External trigger, following engine |
| mst_done | input | 1 | Conversion complete, leading engine |
| mst_data | input | 16 | Conversion result, leading engine |
| slv_done | input | 1 | Conversion complete, following engine |
| slv_data | input | 16 | Conversion result, following engine |
| mst_start | output | 1 | Start pulse to leading engine |
| slv_start | output | 1 | Start pulse to following engine |
| comb_data | output | 32 | Packed result word |
| comb_valid | output | 1 | Paired result ready pulse |

## Verification
The start path is swept over all sixteen codes, crossed with every combination of the two enables and the two triggers. Comparing the cycle offsets of both start pulses separates the four decoded behaviours from one another, and shows whether the reserved codes fall back to independent operation. The result path is driven with master-first, slave-first and simultaneous done pulses under each behaviour, with the transfer enable both set and cleared. These patterns distinguish a pulse raised on the later done from one raised on the first done. A second trigger issued during the spacing window shows whether a pending start locks out new triggers.

// File: rtl/dual_adc_sync_pkg.sv
package dual_adc_sync_pkg;

   typedef enum logic [1:0] {
      SM_FREE = 2'd0,
      SM_JOINT = 2'd1,
      SM_SHORT = 2'd2,
      SM_LONG = 2'd3
   } sync_mode_e;

   function automatic sync_mode_e decode_mode(input logic [3:0] code);
      case (code)
         4'b0110: return SM_JOINT;
         4'b0111: return SM_SHORT;
         4'b1000: return SM_LONG;
         default: return SM_FREE;
      endcase
   endfunction

endpackage

// File: rtl/dual_adc_sync_mode_dec.sv
module dual_adc_sync_mode_dec
   import dual_adc_sync_pkg::*;
#(
   parameter int MODE_W = 4
) (
   input  logic [MODE_W-1:0] code,
   output sync_mode_e        sel,
   output logic              coupled,
   output logic              spaced
);
   if (MODE_W != 4) begin : g_bad_w
      $error("dual_adc_sync_mode_dec: MODE_W must be 4");
   end

   always_comb begin
      sel     = decode_mode(code);
      coupled = (sel != SM_FREE);
      spaced  = (sel == SM_SHORT) || (sel == SM_LONG);
   end
endmodule

// File: rtl/dual_adc_sync_seq.sv
module dual_adc_sync_seq
   import dual_adc_sync_pkg::*;
#(
   parameter int FAST_DLY = 7,
   parameter int SLOW_DLY = 14
) (
   input  logic       clk,
   input  logic       rst_n,
   input  sync_mode_e sel,
   input  logic       coupled,
   input  logic       mst_trig_en,
   input  logic       slv_trig_en,
   input  logic       mst_ext_trig,
   input  logic       slv_ext_trig,
   output logic       mst_start,
   output logic       slv_start
);
   localparam int MAX_DLY = (SLOW_DLY > FAST_DLY) ? SLOW_DLY : FAST_DLY;
   localparam int CNT_W   = (MAX_DLY < 2) ? 1 : $clog2(MAX_DLY);

   if (FAST_DLY < 1 || SLOW_DLY < 1) begin : g_bad_dly
      $error("dual_adc_sync_seq: spacing delays must be at least 1");
   end

   logic             pending;
   logic [CNT_W-1:0] cnt;
   logic             accept;

   assign accept = mst_ext_trig & mst_trig_en & slv_trig_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mst_start <= 1'b0;
         slv_start <= 1'b0;
         pending   <= 1'b0;
         cnt       <= '0;
      end else begin
         mst_start <= 1'b0;
         slv_start <= 1'b0;
         if (pending) begin
            if (cnt == '0) begin
               slv_start <= 1'b1;
               pending   <= 1'b0;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end else if (coupled) begin
            if (accept) begin
               mst_start <= 1'b1;
               case (sel)
                  SM_JOINT: slv_start <= 1'b1;
                  SM_SHORT: begin
                     pending <= 1'b1;
                     cnt     <= CNT_W'(FAST_DLY - 1);
                  end
                  SM_LONG: begin
                     pending <= 1'b1;
                     cnt     <= CNT_W'(SLOW_DLY - 1);
                  end
                  default: ;
               endcase
            end
         end else begin
            mst_start <= mst_ext_trig & mst_trig_en;
            slv_start <= slv_ext_trig & slv_trig_en;
         end
      end
   end
endmodule

// File: rtl/dual_adc_sync_pack.sv
module dual_adc_sync_pack
   import dual_adc_sync_pkg::*;
#(
   parameter int RES_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  sync_mode_e         sel,
   input  logic               coupled,
   input  logic               spaced,
   input  logic               dma_en,
   input  logic               mst_done,
   input  logic [RES_W-1:0]   mst_data,
   input  logic               slv_done,
   input  logic [RES_W-1:0]   slv_data,
   output logic [2*RES_W-1:0] comb_data,
   output logic               comb_valid
);
   localparam int WORD_W = 2 * RES_W;

   if (RES_W < 1 || WORD_W > 64) begin : g_bad_res
      $error("dual_adc_sync_pack: RES_W out of range");
   end

   logic got_m, got_s;
   logic have_m, have_s;

   assign have_m = got_m | mst_done;
   assign have_s = got_s | slv_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         comb_data  <= '0;
         comb_valid <= 1'b0;
         got_m      <= 1'b0;
         got_s      <= 1'b0;
      end else begin
         comb_valid <= 1'b0;
         if (mst_done)
            comb_data[RES_W-1:0] <= mst_data;
         if (slv_done && coupled)
            comb_data[WORD_W-1:RES_W] <= slv_data;
         if (sel == SM_JOINT) begin
            if (have_m && have_s) begin
               comb_valid <= dma_en;
               got_m      <= 1'b0;
               got_s      <= 1'b0;
            end else begin
               got_m <= have_m;
               got_s <= have_s;
            end
         end else begin
            got_m <= 1'b0;
            got_s <= 1'b0;
            if (spaced && slv_done)
               comb_valid <= dma_en;
         end
      end
   end
endmodule

// File: rtl/dual_adc_sync.sv
module dual_adc_sync
   import dual_adc_sync_pkg::*;
#(
   parameter int MODE_W   = 4,
   parameter int RES_W    = 16,
   parameter int FAST_DLY = 7,
   parameter int SLOW_DLY = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [MODE_W-1:0]  mode,
   input  logic               mst_trig_en,
   input  logic               slv_trig_en,
   input  logic               dma_en,
   input  logic               mst_ext_trig,
   input  logic               slv_ext_trig,
   input  logic               mst_done,
   input  logic [RES_W-1:0]   mst_data,
   input  logic               slv_done,
   input  logic [RES_W-1:0]   slv_data,
   output logic               mst_start,
   output logic               slv_start,
   output logic [2*RES_W-1:0] comb_data,
   output logic               comb_valid
);
   sync_mode_e sel;
   logic       coupled, spaced;

   dual_adc_sync_mode_dec #(.MODE_W(MODE_W)) u_dec (
      .code    (mode),
      .sel     (sel),
      .coupled (coupled),
      .spaced  (spaced)
   );

   dual_adc_sync_seq #(.FAST_DLY(FAST_DLY), .SLOW_DLY(SLOW_DLY)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .sel          (sel),
      .coupled      (coupled),
      .mst_trig_en  (mst_trig_en),
      .slv_trig_en  (slv_trig_en),
      .mst_ext_trig (mst_ext_trig),
      .slv_ext_trig (slv_ext_trig),
      .mst_start    (mst_start),
      .slv_start    (slv_start)
   );

   dual_adc_sync_pack #(.RES_W(RES_W)) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (sel),
      .coupled    (coupled),
      .spaced     (spaced),
      .dma_en     (dma_en),
      .mst_done   (mst_done),
      .mst_data   (mst_data),
      .slv_done   (slv_done),
      .slv_data   (slv_data),
      .comb_data  (comb_data),
      .comb_valid (comb_valid)
   );
endmodule

// File: rtl/dual_adc_sync_chk.sv
module dual_adc_sync_chk
   import dual_adc_sync_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] mode,
   input logic       mst_trig_en,
   input logic       slv_trig_en,
   input logic       dma_en,
   input logic       mst_start,
   input logic       slv_start,
   input logic       comb_valid
);
   // R2
   start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mst_start |-> $past(mst_trig_en));

   // R3
   coupled_needs_both_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_start && decode_mode($past(mode)) != SM_FREE) |-> $past(slv_trig_en));

   // R5
   spaced_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_start && (decode_mode($past(mode)) == SM_SHORT ||
                     decode_mode($past(mode)) == SM_LONG)) |-> !slv_start);

   // R10
   no_pair_in_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      comb_valid |-> decode_mode($past(mode)) != SM_FREE);

   // R11
   pair_needs_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
      comb_valid |-> $past(dma_en));
endmodule

bind dual_adc_sync dual_adc_sync_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode        (mode),
   .mst_trig_en (mst_trig_en),
   .slv_trig_en (slv_trig_en),
   .dma_en      (dma_en),
   .mst_start   (mst_start),
   .slv_start   (slv_start),
   .comb_valid  (comb_valid)
);

// File: tb/dual_adc_sync_test.sv
`timescale 1ns/1ps
module dual_adc_sync_test;
   localparam int FAST = 7;
   localparam int SLOW = 14;
   localparam int NONE = 99;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  mode = '0;
   logic        mst_trig_en = 0, slv_trig_en = 0, dma_en = 0;
   logic        mst_ext_trig = 0, slv_ext_trig = 0;
   logic        mst_done = 0, slv_done = 0;
   logic [15:0] mst_data = '0, slv_data = '0;
   logic        mst_start, slv_start, comb_valid;
   logic [31:0] comb_data;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   dual_adc_sync uut (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .mst_trig_en(mst_trig_en), .slv_trig_en(slv_trig_en), .dma_en(dma_en),
      .mst_ext_trig(mst_ext_trig), .slv_ext_trig(slv_ext_trig),
      .mst_done(mst_done), .mst_data(mst_data),
      .slv_done(slv_done), .slv_data(slv_data),
      .mst_start(mst_start), .slv_start(slv_start),
      .comb_data(comb_data), .comb_valid(comb_valid)
   );

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int kind(input logic [3:0] c);
      case (c)
         4'd6: return 1;
         4'd7: return 2;
         4'd8: return 3;
         default: return 0;
      endcase
   endfunction

   // Fires one trigger pattern and measures start offsets.
   task automatic run_trig(input logic [3:0] c, input logic men, input logic sen,
                           input logic mt, input logic st);
      int fm, fs, nm, ns, em, es, k0;
      string tag;
      mode = c; mst_trig_en = men; slv_trig_en = sen;
      @(negedge clk);
      mst_ext_trig = mt; slv_ext_trig = st;
      fm = NONE; fs = NONE; nm = 0; ns = 0;
      for (int k = 1; k <= 24; k++) begin
         @(negedge clk);
         if (k == 1) begin mst_ext_trig = 0; slv_ext_trig = 0; end
         if (mst_start) begin nm++; if (fm == NONE) fm = k; end
         if (slv_start) begin ns++; if (fs == NONE) fs = k; end
      end
      k0 = kind(c);
      if (k0 == 0) begin
         em = (mt && men) ? 1 : NONE;
         es = (st && sen) ? 1 : NONE;
         tag = "R1/R2 free";
      end else begin
         em = (mt && men && sen) ? 1 : NONE;
         es = (em == NONE) ? NONE : (k0 == 1 ? 1 : (k0 == 2 ? 1 + FAST : 1 + SLOW));
         tag = (k0 == 1) ? "R1/R3/R4 joint" : (k0 == 2 ? "R1/R3/R5 short" : "R1/R3/R6 long");
      end
      check($sformatf("%s mode=%0d mst_start offset", tag, c), fm, em);
      check($sformatf("%s mode=%0d slv_start offset", tag, c), fs, es);
      check($sformatf("%s mode=%0d start count", tag, c), nm + ns,
            (em != NONE ? 1 : 0) + (es != NONE ? 1 : 0));
   endtask

   // Drives done pulses at steps tm and ts; checks the paired pulse step.
   task automatic run_data(input logic [3:0] c, input logic dma, input int tm, input int ts,
                           input logic [15:0] a, input logic [15:0] b, input string req);
      int fv, nv, ev, k0;
      logic [31:0] seen;
      mode = c; dma_en = dma;
      @(negedge clk);
      mst_data = a; slv_data = b;
      mst_done = (tm == 0); slv_done = (ts == 0);
      fv = NONE; nv = 0; seen = '0;
      for (int k = 0; k <= 12; k++) begin
         @(negedge clk);
         if (comb_valid) begin nv++; if (fv == NONE) begin fv = k; seen = comb_data; end end
         mst_done = (tm == k + 1); slv_done = (ts == k + 1);
      end
      k0 = kind(c);
      if (!dma || k0 == 0) ev = NONE;
      else if (k0 == 1) ev = (tm > ts) ? tm : ts;
      else ev = ts;
      check($sformatf("%s valid step", req), fv, ev);
      check($sformatf("%s valid count", req), nv, (ev == NONE) ? 0 : 1);
      if (ev != NONE) check($sformatf("R8 %s packed word", req), seen, {b, a});
      if (k0 == 0) check($sformatf("R8 %s free low half", req), comb_data[15:0], a);
      else check($sformatf("R8 %s word after pair", req), comb_data, {b, a});
   endtask

   initial begin
      #1_000_000;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int nm, fs;
      repeat (3) @(negedge clk);
      // R12 reset state
      check("R12 reset mst_start", mst_start, 0);
      check("R12 reset slv_start", slv_start, 0);
      check("R12 reset comb_valid", comb_valid, 0);
      check("R12 reset comb_data", comb_data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 after reset comb_data", comb_data, 0);

      for (int c = 0; c < 16; c++)
         for (int p = 0; p < 16; p++)
            run_trig(4'(c), p[0], p[1], p[2], p[3]);

      // R7 retrigger during short spacing
      mode = 4'd7; mst_trig_en = 1; slv_trig_en = 1;
      @(negedge clk);
      mst_ext_trig = 1;
      nm = 0; fs = NONE;
      for (int k = 1; k <= 24; k++) begin
         @(negedge clk);
         mst_ext_trig = (k == 3);
         if (mst_start) nm++;
         if (slv_start && fs == NONE) fs = k;
      end
      check("R7 retrigger mst_start count", nm, 1);
      check("R7 retrigger slv_start offset", fs, 1 + FAST);

      // R8-R11 result path
      run_data(4'd6, 1, 0, 3, 16'h1111, 16'hA1A1, "R9 joint master first");
      run_data(4'd6, 1, 5, 2, 16'h2222, 16'hB2B2, "R9 joint slave first");
      run_data(4'd6, 1, 4, 4, 16'h3333, 16'hC3C3, "R9 joint simultaneous");
      run_data(4'd6, 0, 1, 3, 16'h4444, 16'hD4D4, "R11 joint no dma");
      run_data(4'd7, 1, 0, 6, 16'h5555, 16'hE5E5, "R10 short");
      run_data(4'd8, 1, 1, 9, 16'h6666, 16'hF6F6, "R10 long");
      run_data(4'd8, 0, 1, 9, 16'h7777, 16'h0707, "R11 long no dma");
      run_data(4'd0, 1, 1, 2, 16'h8888, 16'h1818, "R10 free");
      run_data(4'd3, 1, 2, 2, 16'h9999, 16'h2929, "R1 reserved as free");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule